// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed memory in which every word carries one extra bit saying whether it holds a value that has been produced ("full") or is waiting for one ("empty"). Threads send it requests tagged with a thread ID and an operation code. Plain accesses ignore the tag. Synchronizing accesses obey it. A consumer read or a lock on an empty word does not complete. Instead it is parked in a small wait queue, and the block retries it once a later write marks that word full.

Producer/consumer hand-off works like this. A producer first reserves a word, which marks it empty. Consumers that arrive early then wait. The producer's synchronizing write stores the value, marks the word full and releases the waiters in arrival order.

Mutual exclusion uses the lock and unlock operations. A lock reads a full word and empties it. An unlock writes the word and fills it again. Each unlock therefore hands the word to exactly one waiting lock. Every completed operation returns one response carrying the requester's thread ID and a data word.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is full and every word reads zero; `rsp_valid` is low and `req_ready` is high.
- R2: Operation code 0 (plain read) and 1 (plain write) complete one cycle after acceptance, whatever the tag, and leave the tag unchanged. A plain read returns the stored word. A plain write stores `req_wdata` and returns it. A plain write never releases a waiter.
- R3: Operation code 2 (reserve) marks the word empty, leaves its data unchanged and returns the current word one cycle after acceptance.
- R4: Operation code 3 (consumer read) on a full word returns the word one cycle later and leaves it full. On an empty word it produces no response and waits in the queue.
- R5: Operation codes 4 (producer write) and 6 (unlock) store `req_wdata`, mark the word full and return the written data one cycle after acceptance.
- R6: Operation code 5 (lock) on a full word returns the word one cycle later and marks it empty. On an empty word it produces no response and waits in the queue.
- R7: After a word is marked full, waiting requests for that address are retried one per cycle, oldest first. The first retry completes in the cycle after the write's response. `req_ready` is low while any retry is pending. A retried request that finds the word empty stays queued without a response.
- R8: When several locks wait on one word, a single unlock completes exactly one of them, the oldest.
- R9: When the wait queue holds DEPTH entries, `req_ready` is low for a request that would have to wait. A request that can complete at once stays accepted.
- R10: Operation code 7 behaves as a plain read.
- R11: A response appears only in the cycle after a request was accepted or after a retry cycle, and carries the thread ID of the request it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_op | input | 3 | Operation code (see R2–R10) |
| req_tid | input | TID_W | Requesting thread ID |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_tid | output | TID_W | Thread ID of the completed request |
| rsp_data | output | DATA_W | Read value or written value |

## Verification
A vector table first runs non-waiting sequences: plain accesses on full and empty words, a reserve, producer writes, and lock/unlock pairs. These show whether the tag gates only the synchronizing operations.

Directed tests then park a mix of consumer reads and locks on an empty word. This separates correct oldest-first release from a release that ignores the empty tag left behind by a winning lock. A plain write in the middle of that test must not release anyone.

A filled queue shows that only requests which would wait are held back. Releasing it in thread order confirms that arrival order survives compaction of the queue.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    OP_RD     = 3'd0,
    OP_WR     = 3'd1,
    OP_RSV    = 3'd2,
    OP_SRD    = 3'd3,
    OP_SWR    = 3'd4,
    OP_LOCK   = 3'd5,
    OP_UNLOCK = 3'd6,
    OP_SPARE  = 3'd7
  } fe_op_e;

  function automatic logic op_may_wait(input fe_op_e op);
    return (op == OP_SRD) || (op == OP_LOCK);
  endfunction

endpackage

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_full,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tag_we,
  input  logic              tag_set
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  tag_q;

  assign rd_data = mem_q[addr];
  assign rd_full = tag_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (data_we) begin
      mem_q[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '1;
    end else if (tag_we) begin
      tag_q[addr] <= tag_set;
    end
  end

endmodule

// File: rtl/fe_wait_queue.sv
module fe_wait_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int TID_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_lock,
  input  logic [TID_W-1:0]  push_tid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              wake_en,
  input  logic [ADDR_W-1:0] wake_addr,
  input  logic              pop,
  input  logic              drop,
  output logic              full,
  output logic              sel_valid,
  output logic              sel_lock,
  output logic [TID_W-1:0]  sel_tid,
  output logic [ADDR_W-1:0] sel_addr
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, wake_q, lock_q;
  logic [DEPTH-1:0]  vld_d, wake_d, lock_d;
  logic [TID_W-1:0]  tid_q  [DEPTH];
  logic [TID_W-1:0]  tid_d  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  logic [IW-1:0]     sel_idx, free_idx;
  logic              upd_en;

  // Oldest entry (lowest index) that has been woken.
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && wake_q[i]) begin
        sel_valid = 1'b1;
        sel_idx   = IW'(i);
      end
    end
  end

  // Entries are kept compact, so the first free slot follows the last valid.
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IW'(i);
    end
  end

  assign full     = &vld_q;
  assign sel_lock = lock_q[sel_idx];
  assign sel_tid  = tid_q[sel_idx];
  assign sel_addr = addr_q[sel_idx];
  assign upd_en   = push | pop | drop | wake_en;

  always_comb begin
    vld_d  = vld_q;
    wake_d = wake_q;
    lock_d = lock_q;
    tid_d  = tid_q;
    addr_d = addr_q;
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IW'(i) >= sel_idx) begin
          if (i == DEPTH - 1) begin
            vld_d[i]  = 1'b0;
            wake_d[i] = 1'b0;
          end else begin
            vld_d[i]  = vld_q[(i + 1) % DEPTH];
            wake_d[i] = wake_q[(i + 1) % DEPTH];
            lock_d[i] = lock_q[(i + 1) % DEPTH];
            tid_d[i]  = tid_q[(i + 1) % DEPTH];
            addr_d[i] = addr_q[(i + 1) % DEPTH];
          end
        end
      end
    end
    if (drop) wake_d[sel_idx] = 1'b0;
    if (push) begin
      vld_d[free_idx]  = 1'b1;
      wake_d[free_idx] = 1'b0;
      lock_d[free_idx] = push_lock;
      tid_d[free_idx]  = push_tid;
      addr_d[free_idx] = push_addr;
    end
    if (wake_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (vld_d[i] && (addr_d[i] == wake_addr)) wake_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wake_q <= '0;
      lock_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tid_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else if (upd_en) begin
      vld_q  <= vld_d;
      wake_q <= wake_d;
      lock_q <= lock_d;
      tid_q  <= tid_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/fe_sync_ctrl.sv
module fe_sync_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TID_W  = 3
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              q_full,
  input  logic              sel_valid,
  input  logic              sel_lock,
  input  logic [TID_W-1:0]  sel_tid,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic              q_push,
  output logic              q_push_lock,
  output logic              q_pop,
  output logic              q_drop,
  output logic              q_wake,
  output logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_rdata,
  input  logic              st_full,
  output logic              st_data_we,
  output logic              st_tag_we,
  output logic              st_tag_set,
  output logic              rsp_en,
  output logic [TID_W-1:0]  rsp_tid_d,
  output logic [DATA_W-1:0] rsp_data_d
);
  import fe_pkg::*;

  fe_op_e op;
  logic   would_wait;
  logic   accept;

  assign op          = fe_op_e'(req_op);
  assign st_addr     = sel_valid ? sel_addr : req_addr;
  assign would_wait  = op_may_wait(op) && !st_full;
  assign req_ready   = !sel_valid && !(q_full && would_wait);
  assign accept      = req_valid && req_ready;
  assign q_push_lock = (op == OP_LOCK);

  always_comb begin
    q_push     = 1'b0;
    q_pop      = 1'b0;
    q_drop     = 1'b0;
    q_wake     = 1'b0;
    st_data_we = 1'b0;
    st_tag_we  = 1'b0;
    st_tag_set = 1'b0;
    rsp_en     = 1'b0;
    rsp_tid_d  = req_tid;
    rsp_data_d = st_rdata;
    if (sel_valid) begin
      rsp_tid_d = sel_tid;
      if (st_full) begin
        q_pop  = 1'b1;
        rsp_en = 1'b1;
        if (sel_lock) st_tag_we = 1'b1;
      end else begin
        q_drop = 1'b1;
      end
    end else if (accept) begin
      unique case (op)
        OP_WR: begin
          st_data_we = 1'b1;
          rsp_en     = 1'b1;
          rsp_data_d = req_wdata;
        end
        OP_RSV: begin
          st_tag_we = 1'b1;
          rsp_en    = 1'b1;
        end
        OP_SRD: begin
          if (st_full) rsp_en = 1'b1;
          else         q_push = 1'b1;
        end
        OP_LOCK: begin
          if (st_full) begin
            rsp_en    = 1'b1;
            st_tag_we = 1'b1;
          end else begin
            q_push = 1'b1;
          end
        end
        OP_SWR, OP_UNLOCK: begin
          st_data_we = 1'b1;
          st_tag_we  = 1'b1;
          st_tag_set = 1'b1;
          q_wake     = 1'b1;
          rsp_en     = 1'b1;
          rsp_data_d = req_wdata;
        end
        default: rsp_en = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int TID_W  = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [DATA_W-1:0] rsp_data
);
  logic              q_full, sel_valid, sel_lock;
  logic [TID_W-1:0]  sel_tid;
  logic [ADDR_W-1:0] sel_addr;
  logic              q_push, q_push_lock, q_pop, q_drop, q_wake;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_rdata;
  logic              st_full, st_data_we, st_tag_we, st_tag_set;
  logic              rsp_en;
  logic [TID_W-1:0]  rsp_tid_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic              rsp_valid_q;
  logic [TID_W-1:0]  rsp_tid_q;
  logic [DATA_W-1:0] rsp_data_q;

  fe_sync_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W)) u_ctrl (
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_tid    (req_tid),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .q_full     (q_full),
    .sel_valid  (sel_valid),
    .sel_lock   (sel_lock),
    .sel_tid    (sel_tid),
    .sel_addr   (sel_addr),
    .q_push     (q_push),
    .q_push_lock(q_push_lock),
    .q_pop      (q_pop),
    .q_drop     (q_drop),
    .q_wake     (q_wake),
    .st_addr    (st_addr),
    .st_rdata   (st_rdata),
    .st_full    (st_full),
    .st_data_we (st_data_we),
    .st_tag_we  (st_tag_we),
    .st_tag_set (st_tag_set),
    .rsp_en     (rsp_en),
    .rsp_tid_d  (rsp_tid_d),
    .rsp_data_d (rsp_data_d)
  );

  fe_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (st_addr),
    .rd_data(st_rdata),
    .rd_full(st_full),
    .data_we(st_data_we),
    .wdata  (req_wdata),
    .tag_we (st_tag_we),
    .tag_set(st_tag_set)
  );

  fe_wait_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TID_W(TID_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_lock(q_push_lock),
    .push_tid (req_tid),
    .push_addr(req_addr),
    .wake_en  (q_wake),
    .wake_addr(req_addr),
    .pop      (q_pop),
    .drop     (q_drop),
    .full     (q_full),
    .sel_valid(sel_valid),
    .sel_lock (sel_lock),
    .sel_tid  (sel_tid),
    .sel_addr (sel_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= rsp_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_tid_q  <= '0;
      rsp_data_q <= '0;
    end else if (rsp_en) begin
      rsp_tid_q  <= rsp_tid_d;
      rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_tid   = rsp_tid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int TID_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [TID_W-1:0]  req_tid,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [TID_W-1:0]  rsp_tid,
  input logic [DATA_W-1:0] rsp_data
);
  import fe_pkg::*;

  logic acc;
  assign acc = req_valid && req_ready;

  a_r2_plain_rd_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == OP_RD) |=> (rsp_valid && rsp_tid == $past(req_tid)));

  a_r2_plain_wr_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == OP_WR) |=> (rsp_valid && rsp_data == $past(req_wdata)));

  a_r5_fill_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_op == OP_SWR || req_op == OP_UNLOCK))
      |=> (rsp_valid && rsp_tid == $past(req_tid) && rsp_data == $past(req_wdata)));

  a_r11_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(acc) || $past(!req_ready)));

endmodule

bind fe_sync_mem fe_sync_mem_chk #(.TID_W(TID_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_op   (req_op),
  .req_tid  (req_tid),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_tid  (rsp_tid),
  .rsp_data (rsp_data)
);

// File: tb/fe_sync_mem_bench.sv
module fe_sync_mem_bench;
  localparam int AW = 4, DW = 16, TW = 3;

  logic          clk, rst_n, req_valid, req_ready, rsp_valid;
  logic [2:0]    req_op;
  logic [TW-1:0] req_tid, rsp_tid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic          got_v, got_rdy;
  logic [TW-1:0] got_t;
  logic [DW-1:0] got_d;

  fe_sync_mem u_fe_sync_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_tid(req_tid), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {op[3], tid[3], addr[4], wdata[16], exp_valid[1], exp_data[16]}
  localparam logic [42:0] VEC [14] = '{
    {3'd1, 3'd1, 4'd2, 16'h1234, 1'b1, 16'h1234},  // R2 plain write
    {3'd0, 3'd2, 4'd2, 16'h0000, 1'b1, 16'h1234},  // R2 plain read
    {3'd0, 3'd0, 4'd5, 16'h0000, 1'b1, 16'h0000},  // R1 word is zero after reset
    {3'd2, 3'd3, 4'd2, 16'h0000, 1'b1, 16'h1234},  // R3 reserve
    {3'd0, 3'd1, 4'd2, 16'h0000, 1'b1, 16'h1234},  // R2 plain read of empty word
    {3'd1, 3'd1, 4'd2, 16'h5555, 1'b1, 16'h5555},  // R2 plain write to empty word
    {3'd4, 3'd4, 4'd2, 16'hBEEF, 1'b1, 16'hBEEF},  // R5 producer write
    {3'd3, 3'd5, 4'd2, 16'h0000, 1'b1, 16'hBEEF},  // R4 consumer read full
    {3'd3, 3'd5, 4'd2, 16'h0000, 1'b1, 16'hBEEF},  // R4 word stays full
    {3'd5, 3'd6, 4'd7, 16'h0000, 1'b1, 16'h0000},  // R6 lock full word
    {3'd6, 3'd6, 4'd7, 16'h0042, 1'b1, 16'h0042},  // R5 unlock
    {3'd5, 3'd2, 4'd7, 16'h0000, 1'b1, 16'h0042},  // R6 lock again after unlock
    {3'd6, 3'd2, 4'd7, 16'h0043, 1'b1, 16'h0043},  // R5 unlock
    {3'd7, 3'd1, 4'd7, 16'h0000, 1'b1, 16'h0043}   // R10 spare code reads
  };

  task automatic capture();
    got_v   = rsp_valid;
    got_t   = rsp_tid;
    got_d   = rsp_data;
    got_rdy = req_ready;
  endtask

  task automatic send(input logic [2:0] op, input logic [TW-1:0] tid,
                      input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    @(negedge clk);
    req_op = op; req_tid = tid; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0;
    capture();
  endtask

  task automatic idle();
    @(negedge clk);
    capture();
  endtask

  task automatic chk_rsp(input string req, input logic ev, input logic [TW-1:0] et,
                         input logic [DW-1:0] ed);
    checks++;
    if (got_v !== ev || (ev && (got_t !== et || got_d !== ed))) begin
      errors++;
      $display("FAIL %s: got valid=%b tid=%0d data=%h, expected valid=%b tid=%0d data=%h",
               req, got_v, got_t, got_d, ev, et, ed);
    end
  endtask

  task automatic chk_rdy(input string req, input logic ev);
    checks++;
    if (got_rdy !== ev) begin
      errors++;
      $display("FAIL %s: got req_ready=%b, expected %b", req, got_rdy, ev);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_tid = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    capture();
    chk_rsp("R1 reset response", 1'b0, '0, '0);
    chk_rdy("R1 reset ready", 1'b1);
    rst_n = 1'b1;
    idle();
    chk_rsp("R1 idle after reset", 1'b0, '0, '0);

    foreach (VEC[i]) begin
      send(VEC[i][42:40], VEC[i][39:37], VEC[i][36:33], VEC[i][32:17]);
      chk_rsp($sformatf("R2-table vector %0d (R11 tid)", i), VEC[i][16], VEC[i][39:37], VEC[i][15:0]);
    end

    // R4 R6 R7: mixed waiters on an empty word
    send(3'd2, 3'd0, 4'd3, 16'h0);            chk_rsp("R3 reserve a3", 1'b1, 3'd0, 16'h0);
    send(3'd3, 3'd1, 4'd3, 16'h0);            chk_rsp("R4 consumer read waits", 1'b0, '0, '0);
    send(3'd5, 3'd2, 4'd3, 16'h0);            chk_rsp("R6 lock waits", 1'b0, '0, '0);
    send(3'd3, 3'd3, 4'd3, 16'h0);            chk_rsp("R4 second consumer waits", 1'b0, '0, '0);
    send(3'd1, 3'd7, 4'd3, 16'h1111);         chk_rsp("R2 plain write on empty", 1'b1, 3'd7, 16'h1111);
    idle();                                   chk_rsp("R2 plain write releases no waiter", 1'b0, '0, '0);
    chk_rdy("R2 no retry after plain write", 1'b1);
    send(3'd4, 3'd4, 4'd3, 16'h7777);         chk_rsp("R5 producer write", 1'b1, 3'd4, 16'h7777);
    chk_rdy("R7 ready low during retry", 1'b0);
    idle();                                   chk_rsp("R7 oldest consumer first", 1'b1, 3'd1, 16'h7777);
    chk_rdy("R7 ready low during retry 2", 1'b0);
    idle();                                   chk_rsp("R7 lock second", 1'b1, 3'd2, 16'h7777);
    idle();                                   chk_rsp("R7 consumer re-blocked after lock", 1'b0, '0, '0);
    chk_rdy("R7 ready back high", 1'b1);
    send(3'd6, 3'd5, 4'd3, 16'h8888);         chk_rsp("R5 unlock a3", 1'b1, 3'd5, 16'h8888);
    idle();                                   chk_rsp("R7 remaining consumer", 1'b1, 3'd3, 16'h8888);
    idle();                                   chk_rsp("R7 queue drained", 1'b0, '0, '0);

    // R8: lock contention
    send(3'd5, 3'd1, 4'd9, 16'h0);            chk_rsp("R6 first lock wins", 1'b1, 3'd1, 16'h0);
    send(3'd5, 3'd2, 4'd9, 16'h0);            chk_rsp("R8 lock t2 waits", 1'b0, '0, '0);
    send(3'd5, 3'd3, 4'd9, 16'h0);            chk_rsp("R8 lock t3 waits", 1'b0, '0, '0);
    send(3'd6, 3'd1, 4'd9, 16'h00A1);         chk_rsp("R8 unlock", 1'b1, 3'd1, 16'h00A1);
    idle();                                   chk_rsp("R8 oldest lock gets word", 1'b1, 3'd2, 16'h00A1);
    idle();                                   chk_rsp("R8 only one lock woken", 1'b0, '0, '0);
    send(3'd6, 3'd2, 4'd9, 16'h00A2);         chk_rsp("R8 second unlock", 1'b1, 3'd2, 16'h00A2);
    idle();                                   chk_rsp("R8 last lock gets word", 1'b1, 3'd3, 16'h00A2);
    send(3'd6, 3'd3, 4'd9, 16'h00A3);         chk_rsp("R8 final unlock", 1'b1, 3'd3, 16'h00A3);

    // R9: full wait queue
    send(3'd2, 3'd0, 4'd12, 16'h0);           chk_rsp("R3 reserve a12", 1'b1, 3'd0, 16'h0);
    for (int t = 0; t < 4; t++) begin
      send(3'd3, TW'(t), 4'd12, 16'h0);       chk_rsp("R9 fill queue", 1'b0, '0, '0);
    end
    @(negedge clk);
    req_op = 3'd3; req_tid = 3'd4; req_addr = 4'd12; req_valid = 1'b1;
    #1 got_rdy = req_ready;                   chk_rdy("R9 waiting request held off", 1'b0);
    req_op = 3'd0;
    #1 got_rdy = req_ready;                   chk_rdy("R9 immediate request accepted", 1'b1);
    req_valid = 1'b0;
    send(3'd4, 3'd5, 4'd12, 16'hC0DE);        chk_rsp("R5 release full queue", 1'b1, 3'd5, 16'hC0DE);
    for (int t = 0; t < 4; t++) begin
      idle();                                 chk_rsp("R7 R9 arrival order", 1'b1, TW'(t), 16'hC0DE);
    end
    chk_rdy("R9 ready after drain", 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired, got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule